// File: doc/BRIEF.md
# I2C Target Register Port

This block is a synchronous I2C target that oversamples the bus lines with a faster system clock. It gives an external master byte-wide access to a small register bank through one fixed 7-bit target address. Surrounding logic receives the writable control registers as a flat parallel bus. Surrounding logic also supplies a set of read-only status bytes that the master can read.

The block keeps one register pointer. Reads and writes share it. A write transaction sets the pointer from its first byte after the address, and every data byte that follows advances the pointer. A read transaction streams bytes from the pointer onward. When a transaction is only a sub-address write followed by STOP, it stores no data and only positions the next read. Without such a write, the first read after reset starts at offset 0x00, and each later read continues one past the last byte read. SDA is driven only as an open-drain pull-down. The interface is idle while the active-low reset is low.

Top module: `i2c_regport`

## Requirements
- R1: The target acknowledges only an address byte whose upper seven bits are 1101100 (0xD8 write, 0xD9 read). Any other address gets no ACK, the following bytes are ignored until the next START, and the pointer is unchanged.
- R2: In a write transaction the byte after the address loads the pointer. Each further byte is stored at the pointer, and the pointer then advances by one. Every one of these bytes is acknowledged. Control offset 8+k appears on ctrl_o[8k+7:8k].
- R3: A write that carries only a sub-address and then a STOP changes no register, and the next read begins at that sub-address.
- R4: The first read after reset begins at offset 0x00.
- R5: A read with no sub-address write since the previous read begins one past the last byte read. This also holds after a data write, where it begins one past the last byte written.
- R6: Read bytes leave MSB first. After the master ACKs, the next offset follows. After a NACK the target leaves SDA released for any further SCL clocks.
- R7: Control offsets 0x10 and 0x11 reset to 0xFF, and offsets 0x08 to 0x0F reset to 0x00.
- R8: Offsets 0x00 to 0x03 read status byte k from stat_i[8k+7:8k]. Writes to them and to unimplemented offsets are acknowledged and ignored. Unimplemented offsets (0x04 to 0x07 and 0x12 upward) read as 0x00.
- R9: A START in the middle of a transaction (a repeated START) restarts address decoding.
- R10: While rst_n is low, SDA is never pulled and all control registers hold their reset values.
- R11: A STOP ends the transaction and releases SDA. Bytes clocked after it without a new START are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_pull_o | output | 1 | High to pull SDA low (open-drain enable) |
| stat_i | input | STAT_N*8 | Status bytes readable at offsets 0x00 upward |
| ctrl_o | output | CTRL_N*8 | Control registers, offset 0x08 in the low byte |

## Verification
A wrong pointer shows up on the next read as a byte from the wrong offset, so the bench steers the pointer through every path before reading it back: reset, sub-address only, after a data write, after a NACK, and after an ignored address. A state machine that falls out of step shows up within one byte time, either as a missing or extra ACK in the ninth clock or as SDA held low after a NACK or a STOP. A corrupted register shows up on ctrl_o within a few system clocks of the byte's eighth SCL fall. The bench compares ctrl_o against its model on every clock while the bus is quiet.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_SUB,
    ST_ACK_SUB,
    ST_WDATA,
    ST_ACK_WDATA,
    ST_RDATA,
    ST_RACK
  } bus_state_e;
endpackage

// File: rtl/i2c_regport_sync.sv
module i2c_regport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_sync_n,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] rst_pipe;
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;

  // reset: asserted asynchronously, released after STAGES clocks
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[STAGES-1];

  // line synchronizers plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = ~scl_q & scl_s;
  assign scl_fall  = scl_q & ~scl_s;
  assign start_evt = scl_q & scl_s & sda_q & ~sda_s;
  assign stop_evt  = scl_q & scl_s & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_regport_regs.sv
module i2c_regport_regs #(
  parameter int STAT_N    = 4,
  parameter int CTRL_N    = 10,
  parameter int CTRL_BASE = 8,
  parameter int ONES_BASE = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [7:0]          rd_addr,
  input  logic [STAT_N*8-1:0] stat_i,
  output logic [7:0]          rd_data,
  output logic [CTRL_N*8-1:0] ctrl_o
);
  localparam logic [8:0] CTRL_LO = 9'(CTRL_BASE);
  localparam logic [8:0] CTRL_HI = 9'(CTRL_BASE + CTRL_N);

  logic [CTRL_N-1:0][7:0] ctrl_q;
  logic                   wr_in_ctrl;

  assign wr_in_ctrl = ({1'b0, wr_addr} >= CTRL_LO) && ({1'b0, wr_addr} < CTRL_HI);

  for (genvar g = 0; g < CTRL_N; g++) begin : g_ctrl
    localparam logic [7:0] OFF    = 8'(CTRL_BASE + g);
    localparam logic [7:0] RSTVAL = ((CTRL_BASE + g) >= ONES_BASE) ? 8'hFF : 8'h00;
    logic hit;
    assign hit = wr_en && (wr_addr == OFF);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ctrl_q[g] <= RSTVAL;
      else if (hit) ctrl_q[g] <= wr_data;
    end
  end

  assign ctrl_o = ctrl_q;

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < STAT_N; i++) begin
      if (rd_addr == 8'(i)) rd_data = stat_i[i*8 +: 8];
    end
    for (int i = 0; i < CTRL_N; i++) begin
      if (rd_addr == 8'(CTRL_BASE + i)) rd_data = ctrl_q[i];
    end
  end

  // R8: a write outside the control window leaves every control byte intact
  p_ro_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_in_ctrl) |=> $stable(ctrl_q));
endmodule

// File: rtl/i2c_regport_fsm.sv
module i2c_regport_fsm
  import i2c_regport_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1101100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       sda_s,
  input  logic [7:0] rd_data,
  output logic       sda_pull,
  output logic       wr_en,
  output logic [7:0] ptr,
  output logic [7:0] wr_data
);
  bus_state_e state_q, state_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] tx_q, tx_d;
  logic [7:0] ptr_q, ptr_d;
  logic       oe_q, oe_d;
  logic       rw_q, rw_d;
  logic       mack_q, mack_d;
  logic       rx_state;

  assign rx_state = (state_q == ST_ADDR) || (state_q == ST_SUB) || (state_q == ST_WDATA);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    oe_d    = oe_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    wr_en   = 1'b0;
    if (start_evt) begin
      state_d = ST_ADDR;
      cnt_d   = 4'd0;
      oe_d    = 1'b0;
    end else if (stop_evt) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (rx_state) begin
      if (scl_rise && (cnt_q != 4'd8)) begin
        sh_d  = {sh_q[6:0], sda_s};
        cnt_d = cnt_q + 4'd1;
      end else if (scl_fall && (cnt_q == 4'd8)) begin
        unique case (state_q)
          ST_ADDR: begin
            if (sh_q[7:1] == DEV_ADDR) begin
              rw_d    = sh_q[0];
              oe_d    = 1'b1;
              state_d = ST_ACK_ADDR;
            end else begin
              state_d = ST_IDLE;
            end
          end
          ST_SUB: begin
            ptr_d   = sh_q;
            oe_d    = 1'b1;
            state_d = ST_ACK_SUB;
          end
          default: begin
            wr_en   = 1'b1;
            ptr_d   = ptr_q + 8'd1;
            oe_d    = 1'b1;
            state_d = ST_ACK_WDATA;
          end
        endcase
      end
    end else begin
      unique case (state_q)
        ST_ACK_ADDR: begin
          if (scl_fall) begin
            cnt_d = 4'd0;
            if (rw_q) begin
              tx_d    = rd_data;
              oe_d    = ~rd_data[7];
              state_d = ST_RDATA;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_SUB;
            end
          end
        end
        ST_ACK_SUB, ST_ACK_WDATA: begin
          if (scl_fall) begin
            cnt_d   = 4'd0;
            oe_d    = 1'b0;
            state_d = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_d    = 1'b0;
              ptr_d   = ptr_q + 8'd1;
              state_d = ST_RACK;
            end else begin
              tx_d  = {tx_q[6:0], 1'b0};
              oe_d  = ~tx_q[6];
              cnt_d = cnt_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_d    = rd_data;
              oe_d    = ~rd_data[7];
              cnt_d   = 4'd0;
              state_d = ST_RDATA;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 4'd0;
      sh_q    <= 8'h00;
      tx_q    <= 8'h00;
      ptr_q   <= 8'h00;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      oe_q    <= oe_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_pull = oe_q;
  assign ptr      = ptr_q;
  assign wr_data  = sh_q;

  // R9: a START always leads back to address decoding with SDA released
  p_start_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state_q == ST_ADDR) && (cnt_q == 4'd0) && !oe_q);

  // R11: a STOP returns to idle and frees the line
  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state_q == ST_IDLE) && !oe_q);

  // R11: the idle state never pulls SDA
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !oe_q);

  // R6: SDA drive only changes after an SCL fall, a START or a STOP
  p_oe_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_fall || start_evt || stop_evt) |=> $stable(oe_q));

  // R1: a foreign address is never acknowledged
  p_nomatch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_ADDR) && scl_fall && (cnt_q == 4'd8) && (sh_q[7:1] != DEV_ADDR))
      |=> (state_q == ST_IDLE) && !oe_q);
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter logic [6:0] DEV_ADDR    = 7'b1101100,
  parameter int         STAT_N      = 4,
  parameter int         CTRL_N      = 10,
  parameter int         CTRL_BASE   = 8,
  parameter int         ONES_BASE   = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_pull_o,
  input  logic [STAT_N*8-1:0] stat_i,
  output logic [CTRL_N*8-1:0] ctrl_o
);
  logic       rst_sync_n;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_evt;
  logic       stop_evt;
  logic       wr_en;
  logic [7:0] ptr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;

  i2c_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .rst_sync_n (rst_sync_n),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt)
  );

  i2c_regport_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_s     (sda_s),
    .rd_data   (rd_data),
    .sda_pull  (sda_pull_o),
    .wr_en     (wr_en),
    .ptr       (ptr),
    .wr_data   (wr_data)
  );

  i2c_regport_regs #(
    .STAT_N    (STAT_N),
    .CTRL_N    (CTRL_N),
    .CTRL_BASE (CTRL_BASE),
    .ONES_BASE (ONES_BASE)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (ptr),
    .wr_data (wr_data),
    .rd_addr (ptr),
    .stat_i  (stat_i),
    .rd_data (rd_data),
    .ctrl_o  (ctrl_o)
  );
endmodule

// File: tb/i2c_regport_tb.sv
`timescale 1ns/1ps
module i2c_regport_tb;
  localparam int Q = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl_m;
  logic        sda_m;
  logic        sda_pull;
  logic [31:0] stat;
  logic [79:0] ctrl;
  wire         sda_line = sda_m & ~sda_pull;

  always #2 clk = ~clk;

  i2c_regport u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .stat_i     (stat),
    .ctrl_o     (ctrl)
  );

  int         vec = 0;
  int         bad = 0;
  bit         cmp_en = 1'b0;
  bit         done = 1'b0;
  logic [7:0] mreg [256];
  int         mptr;

  function automatic logic [79:0] mctrl();
    logic [79:0] r;
    for (int i = 0; i < 10; i++) r[i*8 +: 8] = mreg[8+i];
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 256; i++) mreg[i] = 8'h00;
    for (int i = 0; i < 4; i++) mreg[i] = stat[i*8 +: 8];
    mreg[16] = 8'hFF;
    mreg[17] = 8'hFF;
    mptr = 0;
  endtask

  task automatic chk(input string r, input logic [79:0] act, input logic [79:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // per-clock comparison of the control bus against the model
  always @(negedge clk) begin
    if (cmp_en) begin
      vec++;
      if (ctrl !== mctrl()) begin
        bad++;
        $display("FAIL R2 ctrl_o actual=%0h expected=%0h", ctrl, mctrl());
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(Q);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q/2);
    ack = ~sda_line;
    tick(Q/2);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q/2);
      b[i] = sda_line;
      tick(Q/2);
      scl_m = 1'b0;
    end
    sda_m = ~give_ack; tick(Q);
    scl_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic addr(input logic [7:0] ab, input bit exp_ack, input string r);
    logic a;
    bus_start();
    send_byte(ab, a);
    chk(r, a, exp_ack);
  endtask

  task automatic wsub(input logic [7:0] s, input string r);
    logic a;
    send_byte(s, a);
    chk(r, a, 1'b1);
    mptr = s;
  endtask

  task automatic wdat(input logic [7:0] d, input string r);
    logic a;
    cmp_en = 1'b0;
    send_byte(d, a);
    chk(r, a, 1'b1);
    if (mptr >= 8 && mptr < 18) mreg[mptr] = d;
    mptr = (mptr + 1) & 255;
    cmp_en = 1'b1;
  endtask

  task automatic rdat(input bit give_ack, input string r);
    logic [7:0] b;
    recv_byte(give_ack, b);
    chk(r, b, mreg[mptr]);
    mptr = (mptr + 1) & 255;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic a;
    int lows;
    rst_n = 1'b0;
    scl_m = 1'b1;
    sda_m = 1'b1;
    stat  = 32'hC35A81E7;
    model_reset();
    tick(5);
    chk("R7 reset values", ctrl, mctrl());
    chk("R10 no pull in reset", sda_pull, 1'b0);
    rst_n = 1'b1;
    tick(10);
    cmp_en = 1'b1;

    // R4 / R6: first read after reset, ACK then NACK
    addr(8'hD9, 1'b1, "R1 read address ack");
    rdat(1'b1, "R4 first byte from 0x00");
    rdat(1'b0, "R6 next byte after ACK");
    lows = 0;
    for (int k = 0; k < 9; k++) begin
      tick(Q);
      scl_m = 1'b1; tick(Q/2);
      if (!sda_line) lows++;
      tick(Q/2);
      scl_m = 1'b0;
    end
    chk("R6 released after NACK", lows, 0);
    bus_stop();

    // R5: resume one past last read
    addr(8'hD9, 1'b1, "R1");
    rdat(1'b0, "R5 resume after read");
    bus_stop();

    // R2: multi-byte write
    addr(8'hD8, 1'b1, "R1 write address ack");
    wsub(8'h09, "R2 sub ack");
    wdat(8'hA5, "R2 data ack");
    wdat(8'h3C, "R2 data ack");
    bus_stop();
    chk("R2 offset 0x09", ctrl[15:8], 8'hA5);
    chk("R2 offset 0x0A", ctrl[23:16], 8'h3C);

    // R5: read after a data write
    addr(8'hD9, 1'b1, "R1");
    rdat(1'b0, "R5 resume after write");
    bus_stop();

    // R3 / R7: sub-address-only write then read
    addr(8'hD8, 1'b1, "R1");
    wsub(8'h10, "R3 sub ack");
    bus_stop();
    addr(8'hD9, 1'b1, "R1");
    rdat(1'b1, "R3 R7 offset 0x10");
    rdat(1'b0, "R7 offset 0x11");
    bus_stop();
    addr(8'hD9, 1'b1, "R1");
    rdat(1'b0, "R8 unimplemented 0x12");
    bus_stop();

    // R1: foreign address
    addr(8'h5A, 1'b0, "R1 foreign address");
    send_byte(8'hD8, a);
    chk("R1 later byte ignored", a, 1'b0);
    bus_stop();
    addr(8'hD9, 1'b1, "R1");
    rdat(1'b0, "R1 pointer untouched");
    bus_stop();

    // R8: status and unimplemented writes ignored
    addr(8'hD8, 1'b1, "R1");
    wsub(8'h01, "R8 sub ack");
    wdat(8'h77, "R8 status write ack");
    wdat(8'h66, "R8 status write ack");
    bus_stop();
    addr(8'hD8, 1'b1, "R1");
    wsub(8'h01, "R8");
    bus_stop();
    addr(8'hD9, 1'b1, "R1");
    rdat(1'b1, "R8 status 1 kept");
    rdat(1'b0, "R8 status 2 kept");
    bus_stop();
    addr(8'hD8, 1'b1, "R1");
    wsub(8'h05, "R8");
    wdat(8'h99, "R8 unimplemented write ack");
    bus_stop();
    addr(8'hD8, 1'b1, "R1");
    wsub(8'h05, "R8");
    bus_stop();
    addr(8'hD9, 1'b1, "R1");
    rdat(1'b0, "R8 unimplemented reads zero");
    bus_stop();

    // R9: repeated START
    addr(8'hD8, 1'b1, "R1");
    wsub(8'h0C, "R9");
    wdat(8'h42, "R9");
    addr(8'hD8, 1'b1, "R9 repeated start write");
    wsub(8'h0C, "R9");
    addr(8'hD9, 1'b1, "R9 repeated start read");
    rdat(1'b0, "R9 read after repeated start");
    bus_stop();

    // R11: no ACK after STOP without START
    addr(8'hD8, 1'b1, "R1");
    wsub(8'h0E, "R11");
    bus_stop();
    chk("R11 released after stop", sda_pull, 1'b0);
    send_byte(8'hD8, a);
    chk("R11 byte without start", a, 1'b0);
    bus_stop();
    addr(8'hD9, 1'b1, "R1");
    rdat(1'b0, "R11 pointer from sub");
    bus_stop();

    // R10: reset clears registers and silences the bus
    addr(8'hD8, 1'b1, "R1");
    wsub(8'h11, "R10");
    wdat(8'h5C, "R10");
    bus_stop();
    chk("R2 offset 0x11", ctrl[79:72], 8'h5C);
    cmp_en = 1'b0;
    rst_n = 1'b0;
    tick(4);
    model_reset();
    chk("R10 registers reset", ctrl, mctrl());
    chk("R10 no pull", sda_pull, 1'b0);
    addr(8'hD8, 1'b0, "R10 no ack in reset");
    bus_stop();
    rst_n = 1'b1;
    tick(10);
    cmp_en = 1'b1;
    addr(8'hD9, 1'b1, "R1");
    rdat(1'b0, "R4 read from 0x00 after reset");
    bus_stop();

    tick(20);
    finish_run();
  end
endmodule